// File: doc/BRIEF.md
# Dual-Clock FIFO with Graded Fill Flags

This block carries a stream of data words from a producer running on its own write clock to a consumer running on an unrelated read clock. Words are stored in an inferred dual-port array: one port is written only, under the write clock, and the other is read only, under the read clock. Each side owns a binary address counter. The counter is mirrored as a Gray-coded pointer one bit wider than the address. That pointer crosses into the other domain through a chain of flip-flops whose length is a parameter.

Each domain derives its own graded fill indications from its local pointer and the synchronized copy of the remote pointer. The write side reports full, almost full and half full. The read side reports empty, almost empty and half empty. Because the remote pointer always lags the real one, every flag errs on the safe side: the writer may see the queue as fuller than it is, and the reader may see it as emptier than it is. A write presented while full and a read presented while empty are dropped.

Top module: `xdom_fifo`

## Requirements
- R1: After both resets, the read side shows empty, almost empty and half empty all at 1, and the write side shows full, almost full and half full all at 0.
- R2: Words leave in the order they were accepted, with their values intact, across the two unrelated clocks.
- R3: Full is 1 exactly when the write side counts 2^ADDR_W stored words. A write presented while full changes neither the stored contents nor the write pointer, and the counted fill never exceeds 2^ADDR_W.
- R4: Empty is 1 exactly when the read side counts zero words. A read presented while empty leaves the read pointer and the read data output unchanged.
- R5: Almost full is 1 when the write-side count is at least 2^ADDR_W minus AF_MARGIN (14 with the defaults).
- R6: Half full is 1 when the write-side count is at least 2^ADDR_W / 2 (8 with the defaults).
- R7: Almost empty is 1 when the read-side count is at most AE_MARGIN (2 with the defaults).
- R8: Half empty is 1 when the read-side count is below 2^ADDR_W / 2 (8 with the defaults).
- R9: A read accepted at a read-clock rising edge presents its word on rd_data right after that same edge. rd_data holds that word until the next accepted read.
- R10: Each Gray pointer that crosses domains changes in at most one bit per clock of its own domain.
- R11: The flags within one side stay consistent. Full implies almost full and half full. Empty implies almost empty and half empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Queue holds 2^ADDR_W words |
| wr_almost_full | output | 1 | Count at least 2^ADDR_W - AF_MARGIN |
| wr_half_full | output | 1 | Count at least half the depth |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word from the last accepted read |
| rd_empty | output | 1 | No word available |
| rd_almost_empty | output | 1 | Count at most AE_MARGIN |
| rd_half_empty | output | 1 | Count below half the depth |

## Verification
Some properties are watched on every clock edge: the one-bit Gray steps, that dropped writes and dropped reads leave pointers and rd_data untouched, the bound on the counted fill, and the consistency between flags on the same side. Other behaviour can only be shown by the directed scenarios. These cover the exact threshold counts for each graded flag, filling and draining, and ordering and word integrity across the two clocks. They also show that a write dropped while full is truly absent from the data read out later.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   typedef struct packed {
      logic full;
      logic almost_full;
      logic half_full;
   } wr_flags_t;

   typedef struct packed {
      logic empty;
      logic almost_empty;
      logic half_empty;
   } rd_flags_t;

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
   import xfifo_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int AF_MARGIN = 2,
   localparam int PW       = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     rgray_sync,
   output logic [PW-1:0]     wgray,
   output logic [ADDR_W-1:0] waddr,
   output logic              wr_fire,
   output wr_flags_t         flags
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] AF_P    = PW'(DEPTH - AF_MARGIN);
   localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

   function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
      return b;
   endfunction

   logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, fill;

   assign rbin_s   = gray_to_bin(rgray_sync);
   assign fill     = wbin_q - rbin_s;
   assign wr_fire  = wr_en && (fill != DEPTH_P);
   assign wbin_nxt = wbin_q + PW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
      end else if (wr_fire) begin
         wbin_q  <= wbin_nxt;
         wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
   end

   assign wgray             = wgray_q;
   assign waddr             = wbin_q[ADDR_W-1:0];
   assign flags.full        = (fill == DEPTH_P);
   assign flags.almost_full = (fill >= AF_P);
   assign flags.half_full   = (fill >= HALF_P);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.full && wr_en) |=> $stable(wbin_q));

   assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= DEPTH_P);

   assert_wgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray_q ^ $past(wgray_q)) <= 1);

endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
   import xfifo_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int AE_MARGIN = 2,
   localparam int PW       = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [PW-1:0]     wgray_sync,
   output logic [PW-1:0]     rgray,
   output logic [ADDR_W-1:0] raddr,
   output logic              rd_fire,
   output rd_flags_t         flags
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [PW-1:0] AE_P   = PW'(AE_MARGIN);
   localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);

   function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
      return b;
   endfunction

   logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_s, level;

   assign wbin_s   = gray_to_bin(wgray_sync);
   assign level    = wbin_s - rbin_q;
   assign rd_fire  = rd_en && (level != '0);
   assign rbin_nxt = rbin_q + PW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
      end else if (rd_fire) begin
         rbin_q  <= rbin_nxt;
         rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      end
   end

   assign rgray              = rgray_q;
   assign raddr              = rbin_q[ADDR_W-1:0];
   assign flags.empty        = (level == '0);
   assign flags.almost_empty = (level <= AE_P);
   assign flags.half_empty   = (level < HALF_P);

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.empty && rd_en) |=> $stable(rbin_q));

   assert_rgray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray_q ^ $past(rgray_q)) <= 1);

endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cell_q [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge wclk) begin
      if (we) cell_q[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (!rrst_n)  rdata_q <= '0;
      else if (re)  rdata_q <= cell_q[raddr];
   end

   assign rdata = rdata_q;

   assert_rdata_hold_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
      !re |=> $stable(rdata_q));

endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
   import xfifo_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int AF_MARGIN   = 2,
   parameter int AE_MARGIN   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   output logic              wr_almost_full,
   output logic              wr_half_full,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_almost_empty,
   output logic              rd_half_empty
);

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("xdom_fifo: ADDR_W out of range");
      end
      if (AF_MARGIN < 1 || AF_MARGIN >= DEPTH / 2) begin : g_bad_af
         $error("xdom_fifo: AF_MARGIN out of range");
      end
      if (AE_MARGIN < 1 || AE_MARGIN >= DEPTH / 2) begin : g_bad_ae
         $error("xdom_fifo: AE_MARGIN out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xdom_fifo: SYNC_STAGES below 2");
      end
   endgenerate

   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              wr_fire, rd_fire;
   wr_flags_t         wflags;
   rd_flags_t         rflags;

   xfifo_wr_ctl #(.ADDR_W(ADDR_W), .AF_MARGIN(AF_MARGIN)) wr_ctl_i (
      .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_sync(rgray_s),
      .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire), .flags(wflags)
   );

   xfifo_rd_ctl #(.ADDR_W(ADDR_W), .AE_MARGIN(AE_MARGIN)) rd_ctl_i (
      .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_sync(wgray_s),
      .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire), .flags(rflags)
   );

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_sync_i (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
   );

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_sync_i (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
   );

   xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
      .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
      .rclk(rclk), .rrst_n(rrst_n), .re(rd_fire), .raddr(raddr), .rdata(rd_data)
   );

   assign wr_full         = wflags.full;
   assign wr_almost_full  = wflags.almost_full;
   assign wr_half_full    = wflags.half_full;
   assign rd_empty        = rflags.empty;
   assign rd_almost_empty = rflags.almost_empty;
   assign rd_half_empty   = rflags.half_empty;

   assert_full_order_R11: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_full |-> (wr_almost_full && wr_half_full));

   assert_empty_order_R11: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_empty |-> (rd_almost_empty && rd_half_empty));

   assert_empty_read_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd_empty && rd_en) |=> $stable(rd_data));

endmodule

// File: tb/xdom_fifo_tb_top.sv
module xdom_fifo_tb_top;

   localparam int DW    = 8;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int AFM   = 2;
   localparam int AEM   = 2;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          wrst_n = 1'b0, rrst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          wr_full, wr_almost_full, wr_half_full;
   logic          rd_empty, rd_almost_empty, rd_half_empty;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   xdom_fifo #(.DATA_W(DW), .ADDR_W(AW), .AF_MARGIN(AFM), .AE_MARGIN(AEM),
               .SYNC_STAGES(2)) dut_i (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .wr_almost_full(wr_almost_full), .wr_half_full(wr_half_full),
      .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data),
      .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty), .rd_half_empty(rd_half_empty)
   );

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic push(input logic [DW-1:0] v);
      @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge wclk);
      wr_en   = 1'b0;
   endtask

   task automatic pop(output logic [DW-1:0] v);
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic settle();
      repeat (5) @(posedge wclk);
      repeat (5) @(posedge rclk);
      @(negedge rclk);
   endtask

   task automatic check_flags(input string tag, input int n);
      check({tag, " R3 full"},         wr_full,         n == DEPTH);
      check({tag, " R5 almost_full"},  wr_almost_full,  n >= DEPTH - AFM);
      check({tag, " R6 half_full"},    wr_half_full,    n >= DEPTH / 2);
      check({tag, " R4 empty"},        rd_empty,        n == 0);
      check({tag, " R7 almost_empty"}, rd_almost_empty, n <= AEM);
      check({tag, " R8 half_empty"},   rd_half_empty,   n < DEPTH / 2);
   endtask

   task automatic t_reset();
      repeat (6) @(posedge rclk);
      @(negedge wclk); wrst_n = 1'b1;
      @(negedge rclk); rrst_n = 1'b1;
      settle();
      check("R1 empty",        rd_empty,        1);
      check("R1 almost_empty", rd_almost_empty, 1);
      check("R1 half_empty",   rd_half_empty,   1);
      check("R1 full",         wr_full,         0);
      check("R1 almost_full",  wr_almost_full,  0);
      check("R1 half_full",    wr_half_full,    0);
   endtask

   task automatic t_fill_drain();
      logic [DW-1:0] v;
      for (int i = 1; i <= DEPTH; i++) begin
         push(DW'(8'h40 + i));
         settle();
         check_flags("fill", i);
      end
      for (int i = 1; i <= DEPTH; i++) begin
         pop(v);
         check("R2 R9 order", v, 8'h40 + i);
         settle();
         check_flags("drain", DEPTH - i);
      end
   endtask

   task automatic t_overflow();
      logic [DW-1:0] v;
      for (int i = 0; i < DEPTH; i++) push(DW'(8'hA0 + i));
      settle();
      check("R3 full before extra write", wr_full, 1);
      push(8'h55);
      settle();
      check("R3 full after dropped write", wr_full, 1);
      for (int i = 0; i < DEPTH; i++) begin
         pop(v);
         check("R2 R3 data after overflow", v, 8'hA0 + i);
      end
      settle();
      check("R4 empty after drain", rd_empty, 1);
   endtask

   task automatic t_underflow();
      logic [DW-1:0] v;
      pop(v);
      check("R4 rd_data held on empty read", v, 8'hA0 + DEPTH - 1);
      settle();
      check("R4 still empty", rd_empty, 1);
      push(8'h33);
      settle();
      check("R3 R4 count one after dropped ops", rd_almost_empty, 1);
      check("R4 not empty", rd_empty, 0);
      pop(v);
      check("R3 R4 next word is new one", v, 8'h33);
      settle();
      check("R4 empty again", rd_empty, 1);
   endtask

   task automatic t_stream();
      logic [DW-1:0] v;
      int expect_v = 0;
      fork
         for (int i = 0; i < 40; i++) begin
            @(negedge wclk);
            while (wr_full) @(negedge wclk);
            wr_en = 1'b1; wr_data = DW'(i * 7 + 3);
            @(negedge wclk);
            wr_en = 1'b0;
         end
         for (int i = 0; i < 40; i++) begin
            @(negedge rclk);
            while (rd_empty) @(negedge rclk);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
            v = rd_data;
            check("R2 streaming order", v, (expect_v * 7 + 3) & 8'hFF);
            expect_v++;
         end
      join
   endtask

   initial begin
      t_reset();
      t_fill_drain();
      t_overflow();
      t_underflow();
      t_stream();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge wclk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule